// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block is the operand shifter that sits in front of the ALU in a RISC-style datapath. Each cycle it can take one 32-bit operand, a 3-bit shift kind, a shift amount and the current carry flag, and it returns the shifted word together with a shifter carry-out. The amount comes either from a 5-bit immediate field or from the low byte of a register, picked by a single select input.

The supported kinds are logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right that passes through the carry flag. Every kind defines its carry-out for an amount of zero, for amounts inside the word and for amounts at or beyond the word width. The ALU can therefore consume the carry without any special cases of its own. Result and carry are registered. A one-cycle strobe marks each new result.

Top module: `barrel_shifter`

## Requirements
- R1: Kind code 0 is logical left. For an amount from 1 to 32, the result is the operand shifted left with zeros filled in, and the carry-out is operand bit (32 - amount). An amount of 32 therefore gives a zero result and a carry equal to operand bit 0.
- R2: For kind 0 (logical left) and kind 1 (logical right), an amount above 32 gives a zero result and a zero carry-out.
- R3: Kind code 1 is logical right. For an amount from 1 to 32, the result is the operand shifted right with zeros filled in, and the carry-out is operand bit (amount - 1).
- R4: Kind code 2 is arithmetic right. For an amount from 1 to 31, the result fills with the sign bit and the carry-out is operand bit (amount - 1). For an amount of 32 or more, every result bit and the carry-out equal operand bit 31.
- R5: Kind code 3 is rotate right. For a nonzero amount, the operand is rotated by the amount modulo 32, and the carry-out equals bit 31 of the result. An amount of 32 returns the operand unchanged, with the carry equal to its bit 31.
- R6: Kind code 4 is a one-bit rotate through carry. The result is the operand shifted right by one with the incoming carry in bit 31, and the carry-out is operand bit 0. The amount has no effect.
- R7: For kinds 0 to 3, an amount of zero returns the operand unchanged and a carry-out equal to the incoming carry.
- R8: When the amount select is 0, the amount is the 5-bit immediate, zero-extended. When the select is 1, the amount is the 8-bit register amount.
- R9: Kind codes 5, 6 and 7 return the operand unchanged and a carry-out equal to the incoming carry.
- R10: A valid input is captured on the next rising clock edge. The output strobe is high for exactly one cycle per valid input. Result and carry hold their values in cycles with no valid input.
- R11: An active-low synchronous reset clears the result, the carry-out and the output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| operand | input | 32 | Word to shift |
| kind | input | 3 | Shift kind code (0 to 4 defined, 5 to 7 pass-through) |
| amt_sel | input | 1 | 0: immediate amount, 1: register amount |
| imm_amt | input | 5 | Immediate shift amount |
| reg_amt | input | 8 | Low byte of the register shift amount |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| result | output | 32 | Shifted word |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Each result, its carry and its strobe are due exactly one rising edge after the cycle in which the input was presented. The driver applies inputs on the falling edge, and a monitor compares outputs on the following falling edge, half a period after the capturing edge. Each stimulus pushes its expected word and carry into a queue in order, and the monitor pops one entry per strobe. This keeps back-to-back inputs aligned. In cycles without a strobe, the monitor instead checks that the outputs kept the last expected value.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    localparam int DATA_W = 32;
    localparam int IMM_W  = 5;
    localparam int AMT_W  = 8;

    localparam logic [2:0] K_LSL = 3'd0;
    localparam logic [2:0] K_LSR = 3'd1;
    localparam logic [2:0] K_ASR = 3'd2;
    localparam logic [2:0] K_ROR = 3'd3;
    localparam logic [2:0] K_RRC = 3'd4;

endpackage

// File: rtl/bsh_amount_mux.sv
module bsh_amount_mux #(
    parameter int IMM_W = bsh_pkg::IMM_W,
    parameter int AMT_W = bsh_pkg::AMT_W
) (
    input  logic             amt_sel,
    input  logic [IMM_W-1:0] imm_amt,
    input  logic [AMT_W-1:0] reg_amt,
    output logic [AMT_W-1:0] amount
);
    localparam int PAD_W = AMT_W - IMM_W;

    always_comb begin
        if (amt_sel) amount = reg_amt;
        else         amount = {{PAD_W{1'b0}}, imm_amt};
    end
endmodule

// File: rtl/bsh_core.sv
module bsh_core #(
    parameter int W     = bsh_pkg::DATA_W,
    parameter int AMT_W = bsh_pkg::AMT_W
) (
    input  logic [W-1:0]     operand,
    input  logic [2:0]       kind,
    input  logic [AMT_W-1:0] amount,
    input  logic             carry_in,
    output logic [W-1:0]     res,
    output logic             carry
);
    import bsh_pkg::*;

    localparam int ROT_W = $clog2(W);

    logic                amt_zero;
    logic                amt_over;
    logic [2*W-1:0]      left_wide;
    logic [W:0]          right_wide;
    logic signed [W:0]   arith_wide;
    logic [ROT_W-1:0]    rot_amt;
    logic [2*W-1:0]      rot_wide;

    always_comb begin
        amt_zero   = (amount == '0);
        amt_over   = (amount > AMT_W'(W));
        left_wide  = {{W{1'b0}}, operand} << amount;
        right_wide = {operand, 1'b0} >> amount;
        arith_wide = $signed({operand, 1'b0}) >>> amount;
        rot_amt    = amount[ROT_W-1:0];
        rot_wide   = {operand, operand} >> rot_amt;

        res   = operand;
        carry = carry_in;
        case (kind)
            K_LSL: if (amt_over) begin
                       res = '0; carry = 1'b0;
                   end else if (!amt_zero) begin
                       res = left_wide[W-1:0]; carry = left_wide[W];
                   end
            K_LSR: if (amt_over) begin
                       res = '0; carry = 1'b0;
                   end else if (!amt_zero) begin
                       res = right_wide[W:1]; carry = right_wide[0];
                   end
            K_ASR: if (!amt_zero) begin
                       res = arith_wide[W:1]; carry = arith_wide[0];
                   end
            K_ROR: if (!amt_zero) begin
                       res = rot_wide[W-1:0]; carry = rot_wide[W-1];
                   end
            K_RRC: begin
                       res = {carry_in, operand[W-1:1]}; carry = operand[0];
                   end
            default: ;
        endcase
    end
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter #(
    parameter int W     = bsh_pkg::DATA_W,
    parameter int IMM_W = bsh_pkg::IMM_W,
    parameter int AMT_W = bsh_pkg::AMT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     operand,
    input  logic [2:0]       kind,
    input  logic             amt_sel,
    input  logic [IMM_W-1:0] imm_amt,
    input  logic [AMT_W-1:0] reg_amt,
    input  logic             carry_in,
    output logic             out_valid,
    output logic [W-1:0]     result,
    output logic             carry_out
);
    import bsh_pkg::*;

    typedef struct packed {
        logic         vld;
        logic         cy;
        logic [W-1:0] word;
    } state_t;

    state_t           st_d, st_q;
    logic [AMT_W-1:0] eff_amt;
    logic [W-1:0]     core_res;
    logic             core_cy;

    bsh_amount_mux #(.IMM_W(IMM_W), .AMT_W(AMT_W)) u_amt (
        .amt_sel (amt_sel),
        .imm_amt (imm_amt),
        .reg_amt (reg_amt),
        .amount  (eff_amt)
    );

    bsh_core #(.W(W), .AMT_W(AMT_W)) u_core (
        .operand  (operand),
        .kind     (kind),
        .amount   (eff_amt),
        .carry_in (carry_in),
        .res      (core_res),
        .carry    (core_cy)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.word = core_res;
            st_d.cy   = core_cy;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.word;
    assign carry_out = st_q.cy;

    AST_STROBE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(carry_out))); // R10
    AST_RRC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == K_RRC) |=>
        (carry_out == $past(operand[0]) && result[W-1] == $past(carry_in))); // R6
    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind <= K_ROR && eff_amt == '0) |=>
        (result == $past(operand) && carry_out == $past(carry_in))); // R7
    AST_ROR_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == K_ROR && eff_amt != '0) |=> (carry_out == result[W-1])); // R5
    AST_SPARE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind > K_RRC) |=>
        (result == $past(operand) && carry_out == $past(carry_in))); // R9
endmodule

// File: tb/barrel_shifter_bench.sv
module barrel_shifter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [2:0]  kind = '0;
    logic        amt_sel = 1'b0;
    logic [4:0]  imm_amt = '0;
    logic [7:0]  reg_amt = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit seen = 1'b0;
    logic [32:0] last_exp = '0;

    logic [32:0] q_exp[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    barrel_shifter u_barrel_shifter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .kind(kind), .amt_sel(amt_sel), .imm_amt(imm_amt), .reg_amt(reg_amt),
        .carry_in(carry_in), .out_valid(out_valid), .result(result),
        .carry_out(carry_out)
    );

    function automatic logic [32:0] model(logic [31:0] op, logic [2:0] k,
                                          logic [7:0] a, logic ci);
        logic [31:0] v = op;
        logic        c = ci;
        case (k)
            3'd0: for (int i = 0; i < int'(a); i++) begin c = v[31]; v = {v[30:0], 1'b0}; end
            3'd1: for (int i = 0; i < int'(a); i++) begin c = v[0]; v = {1'b0, v[31:1]}; end
            3'd2: for (int i = 0; i < int'(a); i++) begin c = v[0]; v = {v[31], v[31:1]}; end
            3'd3: if (a != 0) begin
                      for (int i = 0; i < int'(a) % 32; i++) v = {v[0], v[31:1]};
                      c = v[31];
                  end
            3'd4: begin c = op[0]; v = {ci, op[31:1]}; end
            default: ;
        endcase
        return {c, v};
    endfunction

    task automatic check(string tag, logic [32:0] act, logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s carry/result actual %0h_%08h expected %0h_%08h",
                     tag, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    task automatic send(string tag, logic [31:0] op, logic [2:0] k, logic sel,
                        logic [4:0] imm, logic [7:0] ra, logic ci, bit idle_after);
        @(negedge clk);
        in_valid = 1'b1; operand = op; kind = k; amt_sel = sel;
        imm_amt = imm; reg_amt = ra; carry_in = ci;
        q_exp.push_back(model(op, k, sel ? ra : {3'b000, imm}, ci));
        q_tag.push_back(tag);
        if (idle_after) begin
            @(negedge clk);
            in_valid = 1'b0; operand = ~op; carry_in = ~ci;
        end
    endtask

    // Monitor: results are due one edge after the input; sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (q_exp.size() == 0) begin
                    check("R10 unexpected strobe", 33'd1, 33'd0);
                end else begin
                    last_exp = q_exp.pop_front();
                    check(q_tag.pop_front(), {carry_out, result}, last_exp);
                    seen = 1'b1;
                end
            end else if (seen) begin
                check("R10 hold", {carry_out, result}, last_exp);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset", {out_valid, carry_out, result}, 34'd0);
        rst_n = 1'b1;

        send("R1 lsl 4",      32'h8000_0001, 3'd0, 1'b0, 5'd4,  8'd0,   1'b0, 1'b1);
        send("R1 lsl 32",     32'h0000_0001, 3'd0, 1'b1, 5'd0,  8'd32,  1'b0, 1'b0);
        send("R1 lsl 31",     32'h0000_0003, 3'd0, 1'b0, 5'd31, 8'd0,   1'b0, 1'b0);
        send("R2 lsl 33",     32'hFFFF_FFFF, 3'd0, 1'b1, 5'd0,  8'd33,  1'b1, 1'b0);
        send("R2 lsr 200",    32'hFFFF_FFFF, 3'd1, 1'b1, 5'd0,  8'd200, 1'b1, 1'b1);
        send("R3 lsr 1",      32'h0000_0003, 3'd1, 1'b0, 5'd1,  8'd0,   1'b0, 1'b0);
        send("R3 lsr 32",     32'h8000_0000, 3'd1, 1'b1, 5'd0,  8'd32,  1'b0, 1'b0);
        send("R4 asr 4",      32'h8000_0018, 3'd2, 1'b0, 5'd4,  8'd0,   1'b0, 1'b0);
        send("R4 asr 32",     32'h8000_0000, 3'd2, 1'b1, 5'd0,  8'd32,  1'b0, 1'b0);
        send("R4 asr 40 neg", 32'h8000_0000, 3'd2, 1'b1, 5'd0,  8'd40,  1'b0, 1'b0);
        send("R4 asr 40 pos", 32'h7FFF_FFFF, 3'd2, 1'b1, 5'd0,  8'd40,  1'b1, 1'b1);
        send("R5 ror 8",      32'h1234_5678, 3'd3, 1'b0, 5'd8,  8'd0,   1'b0, 1'b0);
        send("R5 ror 32",     32'h8765_4321, 3'd3, 1'b1, 5'd0,  8'd32,  1'b0, 1'b0);
        send("R5 ror 36",     32'h0000_0008, 3'd3, 1'b1, 5'd0,  8'd36,  1'b0, 1'b0);
        send("R6 rrc c1",     32'h0000_0002, 3'd4, 1'b0, 5'd9,  8'd0,   1'b1, 1'b0);
        send("R6 rrc c0",     32'hF000_0001, 3'd4, 1'b1, 5'd0,  8'd77,  1'b0, 1'b1);
        send("R7 zero lsl",   32'hA5A5_A5A5, 3'd0, 1'b0, 5'd0,  8'd0,   1'b1, 1'b0);
        send("R7 zero lsr",   32'h5A5A_5A5A, 3'd1, 1'b1, 5'd0,  8'd0,   1'b1, 1'b0);
        send("R7 zero asr",   32'h8000_0001, 3'd2, 1'b0, 5'd0,  8'd0,   1'b0, 1'b0);
        send("R7 zero ror",   32'hC3C3_C3C3, 3'd3, 1'b1, 5'd0,  8'd0,   1'b1, 1'b0);
        send("R8 imm src",    32'h0000_00F0, 3'd1, 1'b0, 5'd3,  8'd9,   1'b0, 1'b0);
        send("R8 reg src",    32'h0000_00F0, 3'd1, 1'b1, 5'd3,  8'd9,   1'b0, 1'b1);
        send("R9 code 5",     32'h1357_9BDF, 3'd5, 1'b0, 5'd7,  8'd0,   1'b1, 1'b0);
        send("R9 code 6",     32'h2468_ACE0, 3'd6, 1'b1, 5'd0,  8'd3,   1'b0, 1'b0);
        send("R9 code 7",     32'hFFFF_0000, 3'd7, 1'b0, 5'd1,  8'd0,   1'b1, 1'b1);

        repeat (3) @(negedge clk);
        check("R10 queue drained", 33'(q_exp.size()), 33'd0);
        check("R10 strobe low when idle", {32'd0, out_valid}, 33'd0);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset after use", {out_valid, carry_out, result}, 34'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule